// File: doc/BRIEF.md
# Dual compare-match 8-bit timer

This block is an 8-bit up-counter with two compare registers and one timer output. A single-cycle register write port loads the counter, the two compare values and a control byte. The control byte holds a clock-select field and an output action for each compare channel. The clock select picks one of three taps of a free-running prescaler, or picks a constant low level that stops the counter. The counter advances once for every falling edge it sees on the selected level. Edges are found by comparing the selected level with a copy of it taken one system clock earlier.

A channel matches when an increment brings the counter to that channel's compare value. Its action then sets, clears or toggles the output, or leaves it unchanged. When both channels match on the same increment, the output takes the action of higher rank. The rank does not depend on which channel asked for it.

The edge detector keeps its registered copy when the selection changes. So a control write that moves the selected level from high to low looks like a falling edge, and it adds one count. The block reproduces this extra count on purpose.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: After reset, the counter output is 0x00 and the timer output is 0.
- R2: Clock select is control bits [1:0]. 00 stops the counter. 01, 10 and 11 advance it once every 8, 64 and 8192 system clock cycles respectively, in steady state.
- R3: The counter changes only on the cycle after a falling edge of the selected level, or on a counter write. It never moves on a rising edge.
- R4: A control write takes the selected level from high to low, for example a change from a high divided tap to the stopped setting. The counter then increments exactly once. The same write made while the level is low adds no count.
- R5: The counter wraps from 0xFF to 0x00 on an increment.
- R6: A write to address 0 loads the counter on the next edge. A load that falls in the same cycle as an increment wins over it. Address 1 is compare A, address 2 is compare B and address 3 is the control byte.
- R7: The action field for channel A is control bits [3:2] and for channel B it is bits [5:4]. The codes are 00 no change, 01 drive 0, 10 drive 1 and 11 toggle. The action is applied on the same edge at which an increment makes the counter equal to that channel's compare value. The timer output never changes at any other time.
- R8: When both channels match on the same increment, the output takes the higher-ranked of the two actions. From highest to lowest the ranks are toggle, drive 1, drive 0, no change.
- R9: Both compare registers reset to 0xFF.

Sentence-per-line source for `## Ports` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 counter, 1 compare A, 2 compare B, 3 control |
| wr_data | input | 8 | Write data |
| cnt_o | output | 8 | Current counter value |
| tmr_o | output | 1 | Timer output level |

## Verification
Two things can land on the same edge. A counter load can coincide with an increment caused by a falling edge. The two compare channels can also match on the same increment. The bench keeps a reference model and uses it to predict when the next falling edge will be seen. It then issues a counter load in exactly that cycle, and it expects the loaded value rather than the incremented one. For the double match, it sets both compare values equal and puts the counter one step below them. It then runs every pairing of the two actions from both starting output levels. Each result is judged against the action of higher rank.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

   // Output action codes; the numeric order is also the rank order.
   typedef enum logic [1:0] {
      ACT_KEEP = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_FLIP = 2'b11
   } act_e;

   localparam logic [1:0] ADDR_CNT  = 2'd0;
   localparam logic [1:0] ADDR_CMPA = 2'd1;
   localparam logic [1:0] ADDR_CMPB = 2'd2;
   localparam logic [1:0] ADDR_CTRL = 2'd3;

   // Control byte field positions
   localparam int CKS_LSB   = 0;
   localparam int ACTA_LSB  = 2;
   localparam int ACTB_LSB  = 4;
   localparam int CTRL_BITS = 6;

   function automatic act_e act_rank_max(input act_e x, input act_e y);
      return (x > y) ? x : y;
   endfunction

   function automatic logic act_apply(input act_e a, input logic cur);
      case (a)
         ACT_LOW:  return 1'b0;
         ACT_HIGH: return 1'b1;
         ACT_FLIP: return ~cur;
         default:  return cur;
      endcase
   endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
   parameter int LOG_1 = 3,
   parameter int LOG_2 = 6,
   parameter int LOG_3 = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [2:0] tap_o
);
   localparam int PRE_W = LOG_3;

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + PRE_W'(1);
   end

   // Bit k-1 of a free-running count has a period of 2**k cycles.
   assign tap_o = {pre_q[LOG_3-1], pre_q[LOG_2-1], pre_q[LOG_1-1]};

endmodule

// File: rtl/tmr8_clk_edge.sv
module tmr8_clk_edge #(
   parameter int N_TAPS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TAPS-1:0] tap_i,
   input  logic [1:0]        cks_i,
   output logic              fall_o
);
   logic [N_TAPS:0] lvl_v;
   logic            sel_lvl;
   logic            prev_q;

   assign lvl_v[0] = 1'b0;   // stopped setting reads as a constant low
   for (genvar g = 1; g <= N_TAPS; g++) begin : g_tap
      assign lvl_v[g] = tap_i[g-1];
   end

   assign sel_lvl = lvl_v[cks_i];

   // The history flop follows the selected level, whatever the selection is.
   // A selection change can therefore look like a falling edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sel_lvl;
   end

   assign fall_o = prev_q & ~sel_lvl;

endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
   import tmr8_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cmp_a_o,
   output logic [CNT_W-1:0] cmp_b_o,
   output act_e             act_a_o,
   output act_e             act_b_o,
   output logic [1:0]       cks_o,
   output logic             cnt_wr_o
);
   logic [CNT_W-1:0]     cmp_a_q, cmp_b_q;
   logic [CTRL_BITS-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_a_q <= '1;
         cmp_b_q <= '1;
         ctrl_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CMPA: cmp_a_q <= wr_data;
            ADDR_CMPB: cmp_b_q <= wr_data;
            ADDR_CTRL: ctrl_q  <= wr_data[CTRL_BITS-1:0];
            default: ;
         endcase
      end
   end

   assign cmp_a_o  = cmp_a_q;
   assign cmp_b_o  = cmp_b_q;
   assign cks_o    = ctrl_q[CKS_LSB +: 2];
   assign act_a_o  = act_e'(ctrl_q[ACTA_LSB +: 2]);
   assign act_b_o  = act_e'(ctrl_q[ACTB_LSB +: 2]);
   assign cnt_wr_o = wr_en && (wr_addr == ADDR_CNT);

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] nxt_o,
   output logic             step_o
);
   logic [CNT_W-1:0] cnt_q;

   assign nxt_o  = cnt_q + CNT_W'(1);   // wraps at the top of the range
   assign step_o = fall_i && !load_i;   // a load suppresses the increment

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (step_o) cnt_q <= nxt_o;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr8_out_ctl.sv
module tmr8_out_ctl
   import tmr8_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int N_CHAN = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         step_i,
   input  logic [CNT_W-1:0]             nxt_i,
   input  logic [N_CHAN-1:0][CNT_W-1:0] cmp_i,
   input  act_e [N_CHAN-1:0]            act_i,
   output logic                         tmr_o
);
   act_e [N_CHAN-1:0] req;
   act_e [N_CHAN:0]   win;
   logic              tmr_q;

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      assign req[c] = (nxt_i == cmp_i[c]) ? act_i[c] : ACT_KEEP;
   end

   // Resolve by action rank, not by channel number.
   assign win[0] = ACT_KEEP;
   for (genvar c = 0; c < N_CHAN; c++) begin : g_rank
      assign win[c+1] = act_rank_max(win[c], req[c]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tmr_q <= 1'b0;
      else if (step_i) tmr_q <= act_apply(win[N_CHAN], tmr_q);
   end

   assign tmr_o = tmr_q;

endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
   import tmr8_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int LOG_1 = 3,
   parameter int LOG_2 = 6,
   parameter int LOG_3 = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_o,
   output logic             tmr_o
);
   localparam int N_TAPS = 3;
   localparam int N_CHAN = 2;

   if (CNT_W < CTRL_BITS) begin : g_bad_width
      $error("CNT_W must hold the control byte fields");
   end
   if (!(LOG_1 >= 1 && LOG_1 < LOG_2 && LOG_2 < LOG_3)) begin : g_bad_taps
      $error("prescaler taps must be strictly increasing and nonzero");
   end

   logic [N_TAPS-1:0] tap;
   logic [1:0]        cks;
   logic              tick_fall;
   logic              cnt_wr;
   logic              step;
   logic [CNT_W-1:0]  cnt_nxt;
   logic [CNT_W-1:0]  cmp_a_q, cmp_b_q;
   act_e              act_a_q, act_b_q;

   tmr8_prescaler #(.LOG_1(LOG_1), .LOG_2(LOG_2), .LOG_3(LOG_3)) u_pre (
      .clk(clk), .rst_n(rst_n), .tap_o(tap)
   );

   tmr8_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cmp_a_o(cmp_a_q), .cmp_b_o(cmp_b_q),
      .act_a_o(act_a_q), .act_b_o(act_b_q),
      .cks_o(cks), .cnt_wr_o(cnt_wr)
   );

   tmr8_clk_edge #(.N_TAPS(N_TAPS)) u_edge (
      .clk(clk), .rst_n(rst_n), .tap_i(tap), .cks_i(cks), .fall_o(tick_fall)
   );

   tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .fall_i(tick_fall), .load_i(cnt_wr), .load_val_i(wr_data),
      .cnt_o(cnt_o), .nxt_o(cnt_nxt), .step_o(step)
   );

   tmr8_out_ctl #(.CNT_W(CNT_W), .N_CHAN(N_CHAN)) u_out (
      .clk(clk), .rst_n(rst_n),
      .step_i(step), .nxt_i(cnt_nxt),
      .cmp_i({cmp_b_q, cmp_a_q}), .act_i({act_b_q, act_a_q}),
      .tmr_o(tmr_o)
   );

endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] cnt_o,
   input logic             tmr_o,
   input logic             fall,
   input logic [CNT_W-1:0] cmp_a,
   input logic [CNT_W-1:0] cmp_b,
   input logic [1:0]       act_a,
   input logic [1:0]       act_b
);
   logic             ld;
   logic [CNT_W-1:0] nxt_c;
   assign ld    = wr_en && (wr_addr == 2'd0);
   assign nxt_c = CNT_W'(cnt_o + CNT_W'(1));

   // R6
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> cnt_o == $past(wr_data));

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !fall) |=> $stable(cnt_o));

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && fall) |=> cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1)));

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall && !ld) |=> $stable(tmr_o));

   // R8
   out_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !ld && ((nxt_c == cmp_a && act_a == 2'b11) ||
                       (nxt_c == cmp_b && act_b == 2'b11)))
      |=> tmr_o != $past(tmr_o));

endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .cnt_o(cnt_o), .tmr_o(tmr_o), .fall(tick_fall),
   .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .act_a(act_a_q), .act_b(act_b_q)
);

// File: tb/tmr8_dual_cmp_bench.sv
module tmr8_dual_cmp_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] cnt_o;
   logic       tmr_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   string phase = "R1";

   always #10 clk = ~clk;   // 50 MHz

   tmr8_dual_cmp u_tmr8_dual_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cnt_o(cnt_o), .tmr_o(tmr_o)
   );

   // ---------- reference model built from the requirements ----------
   logic [12:0] m_pre;
   logic        m_prev;
   logic [1:0]  m_cks;
   logic [1:0]  m_acta, m_actb;
   logic [7:0]  m_cmpa, m_cmpb, m_cnt;
   logic        m_tmr;

   function automatic logic mlvl(input logic [1:0] cks, input logic [12:0] pre);
      case (cks)
         2'd1:    return pre[2];
         2'd2:    return pre[5];
         2'd3:    return pre[12];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic act_do(input logic [1:0] a, input logic t);
      case (a)
         2'd1:    return 1'b0;
         2'd2:    return 1'b1;
         2'd3:    return ~t;
         default: return t;
      endcase
   endfunction

   function automatic logic [1:0] rank(input logic [1:0] a, input logic [1:0] b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic fall_now();
      return m_prev & ~mlvl(m_cks, m_pre);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      logic       f;
      logic [7:0] nx;
      logic [1:0] ra, rb;
      if (!rst_n) begin
         m_pre <= '0; m_prev <= 1'b0; m_cks <= '0; m_acta <= '0; m_actb <= '0;
         m_cmpa <= 8'hFF; m_cmpb <= 8'hFF; m_cnt <= '0; m_tmr <= 1'b0;
      end else begin
         f = fall_now();
         m_prev <= mlvl(m_cks, m_pre);
         m_pre  <= m_pre + 13'd1;
         if (wr_en && wr_addr == 2'd0) m_cnt <= wr_data;
         else if (f) begin
            nx = m_cnt + 8'd1;
            m_cnt <= nx;
            ra = (nx == m_cmpa) ? m_acta : 2'd0;
            rb = (nx == m_cmpb) ? m_actb : 2'd0;
            m_tmr <= act_do(rank(ra, rb), m_tmr);
         end
         if (wr_en && wr_addr == 2'd1) m_cmpa <= wr_data;
         if (wr_en && wr_addr == 2'd2) m_cmpb <= wr_data;
         if (wr_en && wr_addr == 2'd3) begin
            m_cks <= wr_data[1:0]; m_acta <= wr_data[3:2]; m_actb <= wr_data[5:4];
         end
      end
   end

   // ---------- checking ----------
   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         check({phase, " cnt"}, cnt_o, m_cnt);
         check({phase, " out"}, tmr_o, m_tmr);
      end
      if (cyc > 190000) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=<190000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure(input logic [1:0] cks, input int per);
      logic [7:0] c0;
      int n;
      wr(2'd3, {6'd0, cks});
      c0 = cnt_o;
      while (cnt_o == c0) @(negedge clk);
      c0 = cnt_o; n = 0;
      while (cnt_o == c0) begin @(negedge clk); n++; end
      check("R2 period", n, per);
   endtask

   initial begin
      logic [7:0] c0;
      logic       t0;
      process::self().srandom(32'h5EED_1234);
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset cnt", cnt_o, 0);
      check("R1 reset out", tmr_o, 0);

      // R9 + R5: compare A left at reset value, toggle on match
      phase = "R9";
      wr(2'd3, 8'h0D);
      while (cnt_o != 8'hFF) @(negedge clk);
      check("R9 cmp reset FF toggles", tmr_o, 1);
      phase = "R5";
      while (cnt_o == 8'hFF) @(negedge clk);
      check("R5 wrap", cnt_o, 0);

      // R2 periods
      phase = "R2";
      measure(2'd1, 8);
      measure(2'd2, 64);
      measure(2'd3, 8192);

      // R4 spurious count from a high-to-low selection change
      phase = "R4";
      wr(2'd3, 8'h01);
      while (!(mlvl(m_cks, m_pre) && m_prev)) @(negedge clk);
      c0 = cnt_o;
      wr(2'd3, 8'h00);
      idle(20);
      check("R4 spurious +1", cnt_o, 8'(c0 + 8'd1));
      idle(100);
      check("R2 stopped holds", cnt_o, 8'(c0 + 8'd1));
      wr(2'd3, 8'h01);
      while (!(!mlvl(m_cks, m_pre) && !m_prev)) @(negedge clk);
      c0 = cnt_o;
      wr(2'd3, 8'h00);
      idle(20);
      check("R4 no extra count from low", cnt_o, c0);

      // R6 load against a coinciding increment
      phase = "R6";
      wr(2'd3, 8'h01);
      while (!fall_now()) @(negedge clk);
      wr(2'd0, 8'h40);
      check("R6 load wins", cnt_o, 8'h40);
      idle(9);
      check("R6 counts on from load", cnt_o, 8'h41);

      // R8 both channels match on the same increment
      phase = "R8";
      wr(2'd1, 8'h10);
      wr(2'd2, 8'h10);
      for (int rep = 0; rep < 2; rep++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
               wr(2'd3, {2'b00, 2'(b), 2'(a), 2'b00});
               wr(2'd0, 8'h0F);
               idle(2);
               t0 = tmr_o;
               wr(2'd3, {2'b00, 2'(b), 2'(a), 2'b01});
               while (cnt_o != 8'h10) @(negedge clk);
               check("R8 rank", tmr_o, act_do(rank(2'(a), 2'(b)), t0));
            end

      // R7 random traffic against the model
      phase = "R7";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 7) == 0) begin
            case ($urandom_range(0, 3))
               0: wr(2'd0, 8'($urandom));
               1: wr(2'd1, 8'($urandom_range(0, 15)));
               2: wr(2'd2, 8'($urandom_range(0, 15)));
               default: wr(2'd3, {2'b00, 4'($urandom), ($urandom_range(0, 3) == 0) ? 2'd2 : 2'd1});
            endcase
         end else @(negedge clk);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule